// File: doc/BRIEF.md
# Lane Alignment Sequence Generator

This block produces the octet stream that one serial lane sends during the lane alignment phase of link start-up. It emits four octets per clock on a 32-bit word. A control flag accompanies each octet. The lowest octet lane holds the octet sent first. A phase controller issues a one-cycle start pulse together with the number of multiframes to send. The frame length and the number of frames per multiframe come from configuration and set the multiframe length.

Every multiframe is bracketed by a start control character and an end control character. The second multiframe also carries a marker character and a 14-octet link configuration record, and the record ends in a checksum that the block computes itself. Every other position carries a free-running dummy octet counter. The counter is held at zero outside the phase. While the block drives alignment words it raises a flag that tells the downstream scrambler to pass the octets through unchanged. When the last multiframe closes, the block pulses a done strobe and returns to an idle all-zero output.

Top module: `lane_align_gen`

## Requirements
- R1: Every multiframe starts with octet 0x1C (K28.0) and ends with octet 0x7C (K28.3), and both carry a set control flag. Bit i of `tx_ctrl` flags the octet in `tx_data[8i+7:8i]`. Octet lane 0 is sent first, so each multiframe start falls in lane 0 and each multiframe end falls in lane 3.
- R2: In the second multiframe (index 1), octet position 1 is 0x9C (K28.4) with its control flag set. Positions 2 to 15 carry the 14 configuration octets in order, with control flags clear.
- R3: Configuration octets 0 to 12 are `cfg_params[8i+7:8i]` for i = 0..12. Configuration octet 13 is the modulo-256 sum of those 13 octets.
- R4: Every other position is a filler octet with its control flag clear. A filler octet carries an 8-bit counter that is 0 at the first filler of a phase and rises by 1 for each filler sent, across lanes and multiframes. The counter wraps from 255 to 0 and does not advance on control or configuration octets.
- R5: A phase sends `mf_count`+1 multiframes. Each multiframe is `cfg_frame_octets` × `cfg_frames_per_mf` octets long.
- R6: The first word of a phase appears on the cycle after `start` is sampled high while idle. A `start` sampled while a phase is running has no effect.
- R7: The multiframe count, the lengths and the parameter octets are captured when a phase starts. Changes to them during the phase do not alter it.
- R8: `done` is high exactly on the cycle that carries the final end character of the last multiframe. On the next cycle `tx_data` and `tx_ctrl` are zero, unless a new phase has been started.
- R9: `scr_bypass` is high on every cycle that carries an alignment word and low on idle cycles.
- R10: A synchronous active-high `rst` stops any phase and returns the block to idle with the filler counter at zero. The next phase again starts its fillers at 0.
- R11: A configuration is legal only if the multiframe length is a multiple of 4 and at least 20 octets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a phase (sampled while idle) |
| mf_count | input | 8 | Number of multiframes minus one |
| cfg_frame_octets | input | 8 | Octets per frame |
| cfg_frames_per_mf | input | 5 | Frames per multiframe |
| cfg_params | input | 104 | Configuration parameter octets 0..12, octet i at bits 8i+7:8i |
| tx_data | output | 32 | Four octets, lane 0 sent first |
| tx_ctrl | output | 4 | Control flag per octet lane |
| scr_bypass | output | 1 | Keep the scrambler bypassed |
| done | output | 1 | Final word of the phase |

## Verification
Some behaviours are checked by assertions on every cycle. These are: a multiframe start character opens each word-0, the done word closes in an end character, the output goes quiet after done, a running phase continues, the word index advances, any control octet implies the bypass flag, and a phase only starts with a legal length. Other behaviours depend on order and history, so only the bench's scenarios can show them. These include the exact octet content, the wrap of the filler counter past 255, and the checksum value. They also include the captured configuration surviving mid-phase changes, a start held across a phase boundary, and a reset that cuts a phase short.

// File: rtl/lag_pkg.sv
package lag_pkg;
    localparam int LANES        = 4;
    localparam int OCTET_W      = 8;
    localparam int CFG_OCTETS   = 14;
    localparam int PARAM_OCTETS = CFG_OCTETS - 1;
    localparam int MIN_MF_OCT   = 20;

    localparam logic [7:0] SYM_MF_START = 8'h1C; // K28.0
    localparam logic [7:0] SYM_MF_END   = 8'h7C; // K28.3
    localparam logic [7:0] SYM_CFG_MARK = 8'h9C; // K28.4

    typedef enum logic [2:0] {
        KIND_START,
        KIND_END,
        KIND_MARK,
        KIND_CFG,
        KIND_FILL
    } octet_kind_e;

    typedef struct packed {
        logic [OCTET_W-1:0] data;
        logic               ctrl;
    } octet_t;

    function automatic logic [OCTET_W-1:0] param_checksum(
        input logic [PARAM_OCTETS*OCTET_W-1:0] p
    );
        logic [OCTET_W-1:0] s;
        s = '0;
        for (int i = 0; i < PARAM_OCTETS; i++) begin
            s = s + p[i*OCTET_W +: OCTET_W];
        end
        return s;
    endfunction
endpackage

// File: rtl/lag_cfg_store.sv
module lag_cfg_store
    import lag_pkg::*;
#(
    parameter int FW = 8,
    parameter int KW = 5,
    parameter int CW = 8,
    localparam int LW = FW + KW,
    localparam int WW = LW - 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load,
    input  logic [FW-1:0]                     frame_octets,
    input  logic [KW-1:0]                     frames_per_mf,
    input  logic [CW-1:0]                     mf_count,
    input  logic [PARAM_OCTETS*OCTET_W-1:0]   params,
    output logic [WW-1:0]                     last_word,
    output logic [CW-1:0]                     mf_last,
    output logic [CFG_OCTETS*OCTET_W-1:0]     record
);
    logic [LW-1:0] mf_oct;

    always_comb begin
        mf_oct = LW'(frame_octets) * LW'(frames_per_mf);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_word <= '0;
            mf_last   <= '0;
            record    <= '0;
        end else if (load) begin
            last_word <= mf_oct[LW-1:2] - WW'(1);
            mf_last   <= mf_count;
            record    <= {param_checksum(params), params};
        end
    end

    // R11: a phase may only start with a legal multiframe length
    assert_cfg_legal_R11: assert property (@(posedge clk) disable iff (rst)
        load |-> (mf_oct[1:0] == 2'b00 && mf_oct >= LW'(MIN_MF_OCT)));
endmodule

// File: rtl/lag_seq.sv
module lag_seq #(
    parameter int WW = 11,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [WW-1:0] last_word,
    input  logic [CW-1:0] mf_last,
    output logic          active,
    output logic          load,
    output logic [WW-1:0] word_idx,
    output logic [CW-1:0] mf_idx,
    output logic          done
);
    logic at_end;

    always_comb begin
        load   = start && !active;
        at_end = (word_idx == last_word);
        done   = active && at_end && (mf_idx == mf_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            word_idx <= '0;
            mf_idx   <= '0;
        end else if (!active) begin
            if (start) begin
                active   <= 1'b1;
                word_idx <= '0;
                mf_idx   <= '0;
            end
        end else if (at_end) begin
            word_idx <= '0;
            if (mf_idx == mf_last) begin
                active <= 1'b0;
            end else begin
                mf_idx <= mf_idx + CW'(1);
            end
        end else begin
            word_idx <= word_idx + WW'(1);
        end
    end

    // R8: the phase ends right after done
    assert_done_ends_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !active);
    // R6: a running phase is not disturbed before done
    assert_run_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (active && !done) |=> active);
    // R5: words inside a multiframe advance one per cycle
    assert_word_step_R5: assert property (@(posedge clk) disable iff (rst)
        (active && !at_end) |=> (word_idx == $past(word_idx) + WW'(1)));
endmodule

// File: rtl/lag_lane_kind.sv
module lag_lane_kind
    import lag_pkg::*;
#(
    parameter int WW   = 11,
    parameter int LANE = 0
) (
    input  logic [WW-1:0] word_idx,
    input  logic [WW-1:0] last_word,
    input  logic          second_mf,
    output octet_kind_e   kind,
    output logic [3:0]    cfg_idx
);
    localparam int PW = WW + 2;
    localparam logic [1:0] LSEL = 2'(LANE);

    logic [PW-1:0] pos;

    always_comb begin
        pos     = {word_idx, LSEL};
        cfg_idx = pos[3:0] - 4'd2;
        if (pos == '0) begin
            kind = KIND_START;
        end else if (LANE == LANES - 1 && word_idx == last_word) begin
            kind = KIND_END;
        end else if (second_mf && pos == PW'(1)) begin
            kind = KIND_MARK;
        end else if (second_mf && pos >= PW'(2) && pos <= PW'(CFG_OCTETS + 1)) begin
            kind = KIND_CFG;
        end else begin
            kind = KIND_FILL;
        end
    end
endmodule

// File: rtl/lane_align_gen.sv
module lane_align_gen
    import lag_pkg::*;
#(
    parameter int FW = 8,
    parameter int KW = 5,
    parameter int CW = 8,
    localparam int LW = FW + KW,
    localparam int WW = LW - 2,
    localparam int CNTW = $clog2(LANES + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic [CW-1:0]                   mf_count,
    input  logic [FW-1:0]                   cfg_frame_octets,
    input  logic [KW-1:0]                   cfg_frames_per_mf,
    input  logic [PARAM_OCTETS*OCTET_W-1:0] cfg_params,
    output logic [LANES*OCTET_W-1:0]        tx_data,
    output logic [LANES-1:0]                tx_ctrl,
    output logic                            scr_bypass,
    output logic                            done
);
    logic                          active;
    logic                          load;
    logic [WW-1:0]                 word_idx;
    logic [CW-1:0]                 mf_idx;
    logic [WW-1:0]                 last_word;
    logic [CW-1:0]                 mf_last;
    logic [CFG_OCTETS*OCTET_W-1:0] record;
    logic                          second_mf;
    octet_kind_e                   kind    [LANES];
    logic [3:0]                    cfg_idx [LANES];
    octet_t                        lane_oct [LANES];
    logic [CNTW-1:0]               nfill;
    logic [OCTET_W-1:0]            dummy_q;

    lag_cfg_store #(.FW(FW), .KW(KW), .CW(CW)) u_cfg (
        .clk           (clk),
        .rst           (rst),
        .load          (load),
        .frame_octets  (cfg_frame_octets),
        .frames_per_mf (cfg_frames_per_mf),
        .mf_count      (mf_count),
        .params        (cfg_params),
        .last_word     (last_word),
        .mf_last       (mf_last),
        .record        (record)
    );

    lag_seq #(.WW(WW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .last_word (last_word),
        .mf_last   (mf_last),
        .active    (active),
        .load      (load),
        .word_idx  (word_idx),
        .mf_idx    (mf_idx),
        .done      (done)
    );

    assign second_mf = (mf_idx == CW'(1));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lag_lane_kind #(.WW(WW), .LANE(g)) u_kind (
            .word_idx  (word_idx),
            .last_word (last_word),
            .second_mf (second_mf),
            .kind      (kind[g]),
            .cfg_idx   (cfg_idx[g])
        );
    end

    // Octet selection; fillers take consecutive counter values in lane order
    always_comb begin
        nfill = '0;
        for (int i = 0; i < LANES; i++) begin
            lane_oct[i] = '0;
            unique case (kind[i])
                KIND_START: lane_oct[i] = '{data: SYM_MF_START, ctrl: 1'b1};
                KIND_END:   lane_oct[i] = '{data: SYM_MF_END,   ctrl: 1'b1};
                KIND_MARK:  lane_oct[i] = '{data: SYM_CFG_MARK, ctrl: 1'b1};
                KIND_CFG:   lane_oct[i] = '{data: record[{cfg_idx[i], 3'b000} +: OCTET_W],
                                            ctrl: 1'b0};
                KIND_FILL: begin
                    lane_oct[i] = '{data: dummy_q + OCTET_W'(nfill), ctrl: 1'b0};
                    nfill       = nfill + CNTW'(1);
                end
                default:    lane_oct[i] = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            dummy_q <= '0;
        end else begin
            dummy_q <= dummy_q + OCTET_W'(nfill);
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            tx_data[i*OCTET_W +: OCTET_W] = active ? lane_oct[i].data : '0;
            tx_ctrl[i]                    = active && lane_oct[i].ctrl;
        end
        scr_bypass = active;
    end

    // R1: word 0 of a multiframe opens with the start character in lane 0
    assert_mf_open_R1: assert property (@(posedge clk) disable iff (rst)
        (active && word_idx == '0) |-> (tx_ctrl[0] && tx_data[7:0] == SYM_MF_START));
    // R8: the done word closes with the end character in the top lane
    assert_done_closes_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (tx_ctrl[LANES-1] && tx_data[LANES*OCTET_W-1 -: OCTET_W] == SYM_MF_END));
    // R8: idle output right after done
    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (tx_data == '0 && tx_ctrl == '0));
    // R9: no control octet leaves without the bypass flag
    assert_bypass_ctrl_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_ctrl != '0) |-> scr_bypass);
    // R4: the filler counter starts every phase at zero
    assert_dummy_fresh_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (dummy_q == '0));
endmodule

// File: tb/test_lane_align_gen.sv
`timescale 1ns/1ps
module test_lane_align_gen;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [7:0]   mf_count = '0;
    logic [7:0]   cfg_frame_octets = 8'd4;
    logic [4:0]   cfg_frames_per_mf = 5'd5;
    logic [103:0] cfg_params = '0;
    logic [31:0]  tx_data;
    logic [3:0]   tx_ctrl;
    logic         scr_bypass;
    logic         done;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [31:0] q_data [$];
    logic [3:0]  q_ctrl [$];
    logic        q_done [$];
    string       q_tag  [$];

    always #2.5 clk = ~clk;

    lane_align_gen i_lane_align_gen (
        .clk               (clk),
        .rst               (rst),
        .start             (start),
        .mf_count          (mf_count),
        .cfg_frame_octets  (cfg_frame_octets),
        .cfg_frames_per_mf (cfg_frames_per_mf),
        .cfg_params        (cfg_params),
        .tx_data           (tx_data),
        .tx_ctrl           (tx_ctrl),
        .scr_bypass        (scr_bypass),
        .done              (done)
    );

    // Behavioural model: expected words of a whole phase (R1..R5)
    task automatic build_phase();
        int len, nmf, dummy, sum;
        logic [31:0] w;
        logic [3:0] c;
        string tag;
        int oct [14];
        len = int'(cfg_frame_octets) * int'(cfg_frames_per_mf);
        nmf = int'(mf_count) + 1;
        sum = 0;
        for (int i = 0; i < 13; i++) begin
            oct[i] = int'(cfg_params[i*8 +: 8]);
            sum += oct[i];
        end
        oct[13] = sum % 256;
        dummy = 0;
        for (int m = 0; m < nmf; m++) begin
            for (int p = 0; p < len; p++) begin
                int v;
                bit k;
                if (p % 4 == 0) begin w = '0; c = '0; tag = "R4"; end
                if (p == 0) begin v = 'h1C; k = 1; tag = "R1"; end
                else if (p == len - 1) begin v = 'h7C; k = 1; tag = "R1"; end
                else if (m == 1 && p == 1) begin v = 'h9C; k = 1; tag = "R2"; end
                else if (m == 1 && p >= 2 && p <= 15) begin
                    v = oct[p-2]; k = 0; if (tag != "R1") tag = "R3";
                end else begin v = dummy % 256; k = 0; dummy++; end
                w[(p%4)*8 +: 8] = 8'(v);
                c[p%4] = k;
                if (p % 4 == 3) begin
                    q_data.push_back(w);
                    q_ctrl.push_back(c);
                    q_done.push_back(m == nmf - 1 && p == len - 1);
                    q_tag.push_back(tag);
                end
            end
        end
    endtask

    always @(negedge clk) begin
        logic [31:0] ed;
        logic [3:0]  ec;
        logic        edn;
        bit          busy;
        string       tg;
        if (rst) begin
            q_data.delete(); q_ctrl.delete(); q_done.delete(); q_tag.delete();
        end else begin
            busy = (q_data.size() > 0);
            if (busy) begin
                ed = q_data.pop_front(); ec = q_ctrl.pop_front();
                edn = q_done.pop_front(); tg = q_tag.pop_front();
            end else begin
                ed = '0; ec = '0; edn = 1'b0; tg = "R8";
            end
            n_cmp++;
            if (tx_data !== ed || tx_ctrl !== ec) begin
                n_bad++;
                $display("FAIL %s data/ctrl: got %h/%b expected %h/%b", tg, tx_data, tx_ctrl, ed, ec);
            end else if (done !== edn) begin
                n_bad++;
                $display("FAIL R8 done: got %b expected %b", done, edn);
            end else if (scr_bypass !== busy) begin
                n_bad++;
                $display("FAIL R9 scr_bypass: got %b expected %b", scr_bypass, busy);
            end
            // R6: a start seen while a phase runs is ignored by the model too
            if (start && !busy) build_phase();
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic set_cfg(input int f, input int k, input int nm, input int seed);
        cfg_frame_octets  = 8'(f);
        cfg_frames_per_mf = 5'(k);
        mf_count          = 8'(nm);
        for (int i = 0; i < 13; i++) cfg_params[i*8 +: 8] = 8'(seed + i * 37);
    endtask

    task automatic run_phase();
        int words;
        words = (int'(cfg_frame_octets) * int'(cfg_frames_per_mf) / 4) * (int'(mf_count) + 1);
        start = 1'b1;
        tick(1);
        start = 1'b0;
        tick(words + 3);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(4);   // R10: idle zeros after reset, compared each cycle
        // R1 R2 R3 R5: minimum length, four multiframes
        set_cfg(4, 5, 3, 11);
        run_phase();
        // R4: long phase, filler counter wraps past 255
        set_cfg(8, 8, 7, 200);
        run_phase();
        // R5: single multiframe, no record
        set_cfg(3, 12, 0, 5);
        run_phase();
        // R7: configuration changed in the middle of a phase
        set_cfg(4, 10, 2, 90);
        start = 1'b1; tick(1); start = 1'b0;
        tick(5);
        set_cfg(12, 3, 5, 1);
        tick(40);
        // R6: start held high across a whole phase and into the next
        set_cfg(4, 6, 1, 63);
        start = 1'b1;
        tick(6 * 2 + 4);
        start = 1'b0;
        tick(20);
        // R10: reset cuts a phase short; the next phase restarts fillers at 0
        set_cfg(8, 4, 4, 150);
        start = 1'b1; tick(1); start = 1'b0;
        tick(14);
        rst = 1'b1; tick(2); rst = 1'b0;
        tick(2);
        run_phase();
        tick(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule